// File: doc/BRIEF.md
# Clock drift learning averager

This block learns how fast the local clock runs against a time source. At every resynchronization event (a data frame, a control frame or an acknowledgment received from the time-source node) the caller presents two numbers: the timing error seen at that event, in local ticks, and the count of local ticks elapsed since the previous event. The block turns the pair into one drift sample in fixed point, where one unit is 1/1024 ppm. It stores the sample in a circular history and publishes the arithmetic mean of the stored samples as the drift estimate.

Averaging over a window suppresses tick-quantization noise, which is larger than the real variation of the drift. A clear input empties the history when the node switches to a different time source. All arithmetic is done by a shared style of bit-serial signed divider, so the result takes a few tens of cycles to appear and a busy flag covers that time.

Top module: `drift_learn_avg`

## Requirements
- R1: A sample is error × 1 024 000 000 / elapsed, with the quotient truncated toward zero. The error is signed 16-bit, the elapsed count is unsigned 32-bit, and the result is in units of 1/1024 ppm.
- R2: A sample outside the signed 24-bit range is clamped to 8388607 or −8388608, which is about ±8192 ppm.
- R3: `est` equals the sum of the newest DEPTH (default 8) stored samples divided by DEPTH, truncated toward zero. The oldest sample is replaced first.
- R4: While fewer than DEPTH samples are stored, `est` is the mean over the stored samples only. `est_vld` rises together with the first estimate after reset or clear.
- R5: A strobe with an elapsed count of zero is discarded. `busy` stays low, the history and `est` are unchanged, and `zero_err` is high from the next cycle on, staying high until reset.
- R6: `clear` empties the history and aborts any computation in progress. In the next cycle `busy`, `est_vld` and `est` are all 0. If a strobe arrives in the same cycle as `clear`, the strobe is dropped.
- R7: An accepted strobe raises `busy` in the next cycle. `busy` stays high until the new estimate is written. Strobes that arrive while `busy` is high are ignored.
- R8: `est` changes only in the cycle in which a new estimate completes, or after a clear.
- R9: After reset, `busy`, `est`, `est_vld` and `zero_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_vld | input | 1 | Strobe: a new resynchronization measurement is on the inputs |
| tick_err | input | 16 | Signed timing error in ticks |
| tick_elapsed | input | 32 | Unsigned ticks since the previous resynchronization |
| clear | input | 1 | Empty the history and abort work |
| busy | output | 1 | A sample or mean computation is in progress |
| est | output | 24 | Signed drift estimate, 1/1024 ppm units |
| est_vld | output | 1 | `est` holds a mean of at least one sample |
| zero_err | output | 1 | Sticky flag: a strobe with an elapsed count of zero was seen |

## Verification
A clear and a new measurement strobe can fall in the same cycle. The bench drives both together, then checks in the next cycle that `busy` stayed low and that `est_vld` and `est` are zero. A later single sample must then produce an estimate equal to that sample alone, which shows the dropped strobe never reached the history. A clear that lands partway through a divide is also provoked, and is judged the same way.

// File: rtl/drift_learn_pkg.sv
package drift_learn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIFT = 2'd1,
    ST_LOAD  = 2'd2,
    ST_MEAN  = 2'd3
  } dl_state_t;
endpackage

// File: rtl/seq_sdiv.sv
// Bit-serial restoring divider: signed numerator, unsigned denominator,
// quotient truncated toward zero, one quotient bit per cycle.
module seq_sdiv #(
  parameter int N_W = 48,
  parameter int D_W = 32,
  parameter int Q_W = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  abort,
  input  logic signed [N_W-1:0] num,
  input  logic        [D_W-1:0] den,
  output logic signed [Q_W-1:0] quo,
  output logic                  done
);
  localparam int CW = $clog2(N_W + 1);

  logic [N_W-1:0] acc;
  logic [D_W-1:0] rem;
  logic [D_W-1:0] den_r;
  logic           neg;
  logic           run;
  logic [CW-1:0]  cnt;

  logic [D_W:0]   rem_sh;
  logic           ge;
  logic [D_W:0]   rem_nx;
  logic [N_W-1:0] acc_nx;
  logic [N_W-1:0] res_full;

  always_comb begin
    rem_sh   = {rem, acc[N_W-1]};
    ge       = (rem_sh >= {1'b0, den_r});
    rem_nx   = ge ? (rem_sh - {1'b0, den_r}) : rem_sh;
    acc_nx   = {acc[N_W-2:0], ge};
    res_full = neg ? (~acc_nx + 1'b1) : acc_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      rem   <= '0;
      den_r <= '0;
      neg   <= 1'b0;
      run   <= 1'b0;
      cnt   <= '0;
      quo   <= '0;
      done  <= 1'b0;
    end else if (abort) begin
      run  <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      acc   <= num[N_W-1] ? (~num + 1'b1) : num;
      rem   <= '0;
      den_r <= den;
      neg   <= num[N_W-1];
      run   <= 1'b1;
      cnt   <= CW'(N_W);
      done  <= 1'b0;
    end else if (run) begin
      acc <= acc_nx;
      rem <= rem_nx[D_W-1:0];
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
        quo  <= Q_W'(signed'(res_full));
      end else begin
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/drift_hist.sv
// Circular history of drift samples with a running sum and fill count.
module drift_hist #(
  parameter int DEPTH   = 8,
  parameter int DRIFT_W = 24,
  parameter int SUM_W   = DRIFT_W + $clog2(DEPTH) + 1,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr,
  input  logic signed [DRIFT_W-1:0] wdata,
  output logic signed [SUM_W-1:0]   sum,
  output logic        [CNT_W-1:0]   cnt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

  logic signed [DRIFT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]          ptr;
  logic [PTR_W-1:0]          ptr_nx;
  logic                      full;
  logic signed [SUM_W-1:0]   sum_nx;

  generate
    if (POW2) begin : g_wrap_nat
      assign ptr_nx = ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign ptr_nx = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end
  endgenerate

  assign full = (cnt == CNT_W'(DEPTH));

  always_comb begin
    sum_nx = sum + SUM_W'(wdata);
    if (full) sum_nx = sum_nx - SUM_W'(mem[ptr]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr <= '0;
      sum <= '0;
      cnt <= '0;
    end else if (clr) begin
      ptr <= '0;
      sum <= '0;
      cnt <= '0;
    end else if (wr) begin
      mem[ptr] <= wdata;
      ptr      <= ptr_nx;
      sum      <= sum_nx;
      if (!full) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/drift_learn_avg.sv
module drift_learn_avg #(
  parameter int          ERR_W   = 16,
  parameter int          ELAP_W  = 32,
  parameter int          DRIFT_W = 24,
  parameter int          DEPTH   = 8,
  parameter int unsigned SCALE   = 32'd1024000000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sample_vld,
  input  logic signed [ERR_W-1:0]   tick_err,
  input  logic        [ELAP_W-1:0]  tick_elapsed,
  input  logic                      clear,
  output logic                      busy,
  output logic signed [DRIFT_W-1:0] est,
  output logic                      est_vld,
  output logic                      zero_err
);
  import drift_learn_pkg::*;

  localparam int NUM_W = ERR_W + 32;
  localparam int SUM_W = DRIFT_W + $clog2(DEPTH) + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic signed [NUM_W-1:0] D_MAX = NUM_W'((64'sd1 <<< (DRIFT_W - 1)) - 64'sd1);
  localparam logic signed [NUM_W-1:0] D_MIN = -D_MAX - NUM_W'(1);

  function automatic logic signed [NUM_W-1:0] scale_err(input logic signed [ERR_W-1:0] e);
    logic signed [NUM_W-1:0] ex;
    logic signed [NUM_W-1:0] k;
    ex = NUM_W'(e);
    k  = NUM_W'(SCALE);
    return ex * k;
  endfunction

  function automatic logic signed [DRIFT_W-1:0] clamp_drift(input logic signed [NUM_W-1:0] q);
    if (q > D_MAX) return DRIFT_W'(D_MAX);
    if (q < D_MIN) return DRIFT_W'(D_MIN);
    return q[DRIFT_W-1:0];
  endfunction

  dl_state_t state;

  // named internal events
  logic sample_accept;
  logic sample_drop;
  logic hist_wr;
  logic mean_start;
  logic mean_done;

  logic signed [NUM_W-1:0]   drift_q;
  logic                      drift_done;
  logic signed [DRIFT_W-1:0] mean_q;
  logic                      mean_div_done;
  logic signed [SUM_W-1:0]   hist_sum;
  logic        [CNT_W-1:0]   hist_cnt;

  assign sample_accept = (state == ST_IDLE) && sample_vld && !clear && (tick_elapsed != '0);
  assign sample_drop   = (state == ST_IDLE) && sample_vld && !clear && (tick_elapsed == '0);
  assign hist_wr       = (state == ST_DRIFT) && drift_done && !clear;
  assign mean_start    = (state == ST_LOAD) && !clear;
  assign mean_done     = (state == ST_MEAN) && mean_div_done && !clear;
  assign busy          = (state != ST_IDLE);

  seq_sdiv #(.N_W(NUM_W), .D_W(ELAP_W), .Q_W(NUM_W)) drift_div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sample_accept),
    .abort (clear),
    .num   (scale_err(tick_err)),
    .den   (tick_elapsed),
    .quo   (drift_q),
    .done  (drift_done)
  );

  drift_hist #(.DEPTH(DEPTH), .DRIFT_W(DRIFT_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) hist_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clear),
    .wr    (hist_wr),
    .wdata (clamp_drift(drift_q)),
    .sum   (hist_sum),
    .cnt   (hist_cnt)
  );

  seq_sdiv #(.N_W(SUM_W), .D_W(CNT_W), .Q_W(DRIFT_W)) mean_div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mean_start),
    .abort (clear),
    .num   (hist_sum),
    .den   (hist_cnt),
    .quo   (mean_q),
    .done  (mean_div_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (clear) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (sample_accept) state <= ST_DRIFT;
        ST_DRIFT: if (drift_done)    state <= ST_LOAD;
        ST_LOAD:                     state <= ST_MEAN;
        ST_MEAN:  if (mean_div_done) state <= ST_IDLE;
        default:                     state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est     <= '0;
      est_vld <= 1'b0;
    end else if (clear) begin
      est     <= '0;
      est_vld <= 1'b0;
    end else if (mean_done) begin
      est     <= mean_q;
      est_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           zero_err <= 1'b0;
    else if (sample_drop) zero_err <= 1'b1;
  end
endmodule

// File: rtl/drift_learn_avg_chk.sv
module drift_learn_avg_chk #(
  parameter int DRIFT_W = 24,
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      clear,
  input logic                      busy,
  input logic signed [DRIFT_W-1:0] est,
  input logic                      est_vld,
  input logic                      zero_err,
  input logic                      sample_accept,
  input logic                      sample_drop,
  input logic                      mean_done,
  input logic [CNT_W-1:0]          hist_cnt
);
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_accept |=> busy);

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_drop |=> (zero_err && !busy));

  // R5
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_err |=> zero_err);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!busy && !est_vld && est == '0));

  // R8
  est_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mean_done && !clear) |=> $stable(est));

  // R4
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(est_vld) |-> $past(mean_done));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_cnt <= CNT_W'(DEPTH));
endmodule

bind drift_learn_avg drift_learn_avg_chk #(
  .DRIFT_W (DRIFT_W),
  .DEPTH   (DEPTH),
  .CNT_W   (CNT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .clear         (clear),
  .busy          (busy),
  .est           (est),
  .est_vld       (est_vld),
  .zero_err      (zero_err),
  .sample_accept (sample_accept),
  .sample_drop   (sample_drop),
  .mean_done     (mean_done),
  .hist_cnt      (hist_cnt)
);

// File: tb/drift_learn_avg_tb.sv
module drift_learn_avg_tb_top;
  localparam int    DEPTH = 8;
  localparam longint DMAX = 64'sd8388607;
  localparam longint DMIN = -64'sd8388608;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sample_vld = 1'b0;
  logic signed [15:0] tick_err = '0;
  logic [31:0]        tick_elapsed = '0;
  logic               clear = 1'b0;
  logic               busy;
  logic signed [23:0] est;
  logic               est_vld;
  logic               zero_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  longint mh[DEPTH];
  int     mcnt = 0;
  int     mptr = 0;

  always #5 clk = ~clk;

  drift_learn_avg dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_vld   (sample_vld),
    .tick_err     (tick_err),
    .tick_elapsed (tick_elapsed),
    .clear        (clear),
    .busy         (busy),
    .est          (est),
    .est_vld      (est_vld),
    .zero_err     (zero_err)
  );

  task automatic summary_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<150000", cyc);
      summary_end();
    end
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_sample(longint e, longint el);
    longint q;
    q = (e * 64'sd1024000000) / el;
    if (q > DMAX) q = DMAX;
    if (q < DMIN) q = DMIN;
    return q;
  endfunction

  function automatic longint ref_mean();
    longint s = 0;
    for (int i = 0; i < mcnt; i++) s += mh[i];
    return s / mcnt;
  endfunction

  task automatic model_push(longint v);
    mh[mptr] = v;
    mptr = (mptr + 1) % DEPTH;
    if (mcnt < DEPTH) mcnt++;
  endtask

  task automatic model_clear();
    mcnt = 0;
    mptr = 0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " busy falls"}, longint'(busy), 0);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
  endtask

  // one accepted sample, optionally with a stray strobe while busy
  task automatic run_sample(string req, longint e, longint el, bit stray);
    @(negedge clk);
    sample_vld   = 1'b1;
    tick_err     = 16'(e);
    tick_elapsed = 32'(el);
    @(negedge clk);
    sample_vld = 1'b0;
    chk("R7 busy after strobe", longint'(busy), 1);
    if (stray) begin
      @(negedge clk);
      @(negedge clk);
      sample_vld   = 1'b1;
      tick_err     = 16'sd12345;
      tick_elapsed = 32'd7;
      @(negedge clk);
      sample_vld = 1'b0;
    end
    wait_idle(req);
    model_push(ref_sample(e, el));
    chk(req, longint'(est), ref_mean());
    chk({req, " est_vld"}, longint'(est_vld), 1);
  endtask

  initial begin
    longint errs[9] = '{-32768, -2000, -37, -1, 0, 1, 5, 999, 32767};
    longint els[6]  = '{1, 3, 1000, 40000, 4000000, 64'hFFFF_FFFF};
    longint keep;

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", longint'(busy), 0);
    chk("R9 est", longint'(est), 0);
    chk("R9 est_vld", longint'(est_vld), 0);
    chk("R9 zero_err", longint'(zero_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 single-sample sweep: each estimate equals one clamped sample
    foreach (errs[i]) begin
      foreach (els[j]) begin
        do_clear();
        run_sample((ref_sample(errs[i], els[j]) == DMAX ||
                    ref_sample(errs[i], els[j]) == DMIN) ? "R2 clamp" : "R1 scale",
                   errs[i], els[j], 1'b0);
      end
    end

    // R4 partial fill, then R3 sliding window with wraparound
    do_clear();
    chk("R4 est_vld low after clear", longint'(est_vld), 0);
    for (int k = 0; k < 20; k++) begin
      run_sample((k < DEPTH) ? "R4 partial mean" : "R3 window mean",
                 (k * 7919) % 4001 - 2000, 1000 + k * 333, 1'b0);
    end

    // R7 strobes while busy are ignored
    for (int k = 0; k < 3; k++) run_sample("R7 ignore while busy", 300 - k * 250, 12345, 1'b1);

    // R5 zero elapsed count
    keep = longint'(est);
    @(negedge clk);
    sample_vld   = 1'b1;
    tick_err     = 16'sd500;
    tick_elapsed = '0;
    @(negedge clk);
    sample_vld = 1'b0;
    chk("R5 no busy on zero", longint'(busy), 0);
    chk("R5 zero_err set", longint'(zero_err), 1);
    chk("R5 est unchanged", longint'(est), keep);
    run_sample("R5 history unchanged", -77, 5000, 1'b0);
    chk("R5 zero_err sticky", longint'(zero_err), 1);

    // R6 clear and strobe in the same cycle
    @(negedge clk);
    clear        = 1'b1;
    sample_vld   = 1'b1;
    tick_err     = 16'sd900;
    tick_elapsed = 32'd10;
    @(negedge clk);
    clear      = 1'b0;
    sample_vld = 1'b0;
    model_clear();
    chk("R6 busy after clear+strobe", longint'(busy), 0);
    chk("R6 est_vld after clear", longint'(est_vld), 0);
    chk("R6 est after clear", longint'(est), 0);
    run_sample("R6 only new sample", 41, 2000, 1'b0);

    // R6 clear in the middle of a divide
    @(negedge clk);
    sample_vld   = 1'b1;
    tick_err     = 16'sd3;
    tick_elapsed = 32'd9;
    @(negedge clk);
    sample_vld = 1'b0;
    repeat (10) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
    chk("R6 abort busy", longint'(busy), 0);
    chk("R6 abort est_vld", longint'(est_vld), 0);
    repeat (80) @(negedge clk);
    chk("R8 est held after abort", longint'(est), 0);
    run_sample("R6 after abort", -19, 777, 1'b0);

    summary_end();
  end
endmodule